// File: doc/BRIEF.md
# Frequency Lock Window Monitor

This block decides whether a clock-recovery loop has frequency lock. It works entirely in the reference-clock domain. A divided copy of the loop oscillator arrives as an asynchronous square wave. The block synchronizes it and counts its rising edges over a measurement window of a fixed number of reference cycles. The captured count is then compared with the count expected for the selected data-rate code.

The loop has two states. Frequency acquisition holds while the loop is unlocked, and phase acquisition holds while it is locked. Entry into lock and exit from lock use different error limits:

- Lock is gained only when the count is within 1% of the expected value.
- Lock is lost only when the error exceeds 2%.

Changing the rate code always drops lock and restarts the window. An external disqualify input, sampled when a window closes, vetoes lock; a supervisor that detects harmonic lock drives it. Each finished window is marked by a one-cycle pulse.

Top module: `freq_lock_monitor`

## Requirements
- R1: While `rst_n` is low, `lock_det`, `pa_active` and `meas_done` are all 0.
- R2: `meas_done` is a one-cycle pulse. It is high in the cycle after the 2^WIN_LOG2-th rising `ref_clk` edge counted from reset release, from the last rate-code change, or from the previous window close. A window cut short by a rate-code change produces no pulse.
- R3: The expected count for a window is 2^WIN_LOG2 / D. D is the rate divider for `rate_sel`: code 0 gives 16, 1 gives 12, 2 gives 8, 3 gives 6, 4 gives 4 and 5 gives 2. The count is the number of rising edges of `osc_div_in`.
- R4: From the unlocked state, the block becomes locked at a window close when |count − expected| × 100 ≤ expected × 1.
- R5: In the band 1% < error ≤ 2%, the state does not change: a locked loop stays locked and an unlocked loop stays unlocked.
- R6: From the locked state, the block becomes unlocked at a window close when |count − expected| × 100 > expected × 2.
- R7: `pa_active` (phase acquisition) equals `lock_det` in every cycle, so frequency acquisition is active exactly while the loop is unlocked.
- R8: A change of `rate_sel` clears `lock_det` on the first `ref_clk` edge that sees the new code, and it restarts the window.
- R9: If `harm_dq` is high on the edge that closes a window, the block is unlocked after that edge, whatever the count.
- R10: Rate codes 6 and 7 never produce lock.
- R11: `lock_det` changes only on an edge that closes a window or on an edge that sees a rate-code change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_div_in | input | 1 | Divided oscillator square wave, asynchronous to `ref_clk` |
| rate_sel | input | 3 | Data-rate code, synchronous to `ref_clk` |
| harm_dq | input | 1 | Harmonic-lock disqualify, sampled at window close |
| lock_det | output | 1 | High while frequency-locked |
| pa_active | output | 1 | High while in phase acquisition, low in frequency acquisition |
| meas_done | output | 1 | One-cycle pulse after each completed window |

## Verification
Lock state changes on the very edge that closes a window, which is the 2^WIN_LOG2-th edge after reset release or after a code change. `meas_done` is high during the cycle that follows that edge. A rate-code change is seen on the first edge after the code is driven, and `lock_det` is low from that edge on. The bench models these edge counts itself and compares every output on each falling edge. It changes frequency, rate code or disqualify only in the cycle just after a window closes. The applied frequency errors are kept several counts away from both thresholds, so that the few edges carried across a window boundary by the synchronizer cannot change a decision.

// File: rtl/flm_pkg.sv
`timescale 1ns/1ps
package flm_pkg;

  typedef enum logic {
    ST_FREQ_ACQ  = 1'b0,
    ST_PHASE_ACQ = 1'b1
  } loop_st_e;

  localparam int unsigned NUM_RATES = 6;

  // rate divider per code; zero marks an unsupported code
  function automatic int unsigned rate_div(input logic [2:0] code);
    case (code)
      3'd0:    return 16;
      3'd1:    return 12;
      3'd2:    return 8;
      3'd3:    return 6;
      3'd4:    return 4;
      3'd5:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic rate_valid(input logic [2:0] code);
    return (32'(code) < NUM_RATES);
  endfunction

  function automatic int unsigned exp_count(input logic [2:0] code,
                                            input int unsigned win_log2);
    int unsigned d;
    d = rate_div(code);
    if (d == 0) return 0;
    return (32'd1 << win_log2) / d;
  endfunction

  // true when |cnt - ref| is within pct percent of ref
  function automatic logic within_pct(input int unsigned cnt,
                                      input int unsigned refc,
                                      input int unsigned pct);
    longint unsigned diff;
    diff = (cnt > refc) ? longint'(cnt - refc) : longint'(refc - cnt);
    return (diff * 64'd100) <= (longint'(refc) * longint'(pct));
  endfunction

endpackage

// File: rtl/flm_edge_sync.sv
`timescale 1ns/1ps
module flm_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

  // R3
  no_back_to_back_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/flm_window.sv
`timescale 1ns/1ps
module flm_window #(
  parameter int unsigned WIN_LOG2 = 12,
  parameter int unsigned CNT_W    = WIN_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             edge_i,
  output logic             win_end,
  output logic [CNT_W-1:0] cnt_final
);
  logic [WIN_LOG2-1:0] win_cnt_q;
  logic [CNT_W-1:0]    edge_cnt_q;

  assign win_end   = (win_cnt_q == {WIN_LOG2{1'b1}}) && !restart;
  assign cnt_final = edge_cnt_q + CNT_W'(edge_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt_q  <= '0;
      edge_cnt_q <= '0;
    end else if (restart) begin
      win_cnt_q  <= '0;
      edge_cnt_q <= '0;
    end else if (win_end) begin
      win_cnt_q  <= '0;
      edge_cnt_q <= '0;
    end else begin
      win_cnt_q  <= win_cnt_q + 1'b1;
      edge_cnt_q <= cnt_final;
    end
  end

  // R2
  single_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !win_end);

  // R2
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (win_cnt_q == '0));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(edge_cnt_q) <= ((32'd1 << WIN_LOG2) / 2) + 1);

endmodule

// File: rtl/flm_lock_fsm.sv
`timescale 1ns/1ps
module flm_lock_fsm
  import flm_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 12,
  parameter int unsigned CNT_W    = WIN_LOG2 + 1,
  parameter int unsigned LOCK_PCT = 1,
  parameter int unsigned DROP_PCT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_chg,
  input  logic [2:0]       rate_code,
  input  logic             win_end,
  input  logic [CNT_W-1:0] cnt_final,
  input  logic             harm_dq,
  output loop_st_e         state,
  output logic             done
);
  int unsigned expected;
  logic        acq_ok;
  logic        hold_ok;
  logic        code_ok;
  loop_st_e    next_st;

  always_comb begin
    expected = exp_count(rate_code, WIN_LOG2);
    code_ok  = rate_valid(rate_code);
    acq_ok   = within_pct(32'(cnt_final), expected, LOCK_PCT);
    hold_ok  = within_pct(32'(cnt_final), expected, DROP_PCT);
    next_st  = state;
    if (rate_chg) begin
      next_st = ST_FREQ_ACQ;
    end else if (win_end) begin
      if (harm_dq || !code_ok)        next_st = ST_FREQ_ACQ;
      else if (state == ST_FREQ_ACQ)  next_st = acq_ok  ? ST_PHASE_ACQ : ST_FREQ_ACQ;
      else                            next_st = hold_ok ? ST_PHASE_ACQ : ST_FREQ_ACQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FREQ_ACQ;
      done  <= 1'b0;
    end else begin
      state <= next_st;
      done  <= win_end && !rate_chg;
    end
  end

  // R4
  acquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !rate_chg && !harm_dq && code_ok && state == ST_FREQ_ACQ && acq_ok)
      |=> state == ST_PHASE_ACQ);

  // R6
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && state == ST_PHASE_ACQ && !hold_ok) |=> state == ST_FREQ_ACQ);

  // R8
  rate_change_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_chg |=> state == ST_FREQ_ACQ);

  // R9
  disqualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && harm_dq) |=> state == ST_FREQ_ACQ);

  // R10
  bad_code_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PHASE_ACQ) |-> code_ok);

  // R11
  change_only_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state) |-> $past(win_end || rate_chg));

endmodule

// File: rtl/freq_lock_monitor.sv
`timescale 1ns/1ps
module freq_lock_monitor
  import flm_pkg::*;
#(
  parameter int unsigned WIN_LOG2    = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOCK_PCT    = 1,
  parameter int unsigned DROP_PCT    = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       osc_div_in,
  input  logic [2:0] rate_sel,
  input  logic       harm_dq,
  output logic       lock_det,
  output logic       pa_active,
  output logic       meas_done
);
  localparam int unsigned CNT_W = WIN_LOG2 + 1;

  logic [2:0]       rate_q;
  logic             rate_chg;
  logic             osc_rise;
  logic             win_end;
  logic [CNT_W-1:0] cnt_final;
  loop_st_e         state;

  assign rate_chg = (rate_sel != rate_q);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rate_q <= 3'd0;
    else        rate_q <= rate_sel;
  end

  flm_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .async_in (osc_div_in),
    .rise     (osc_rise)
  );

  flm_window #(
    .WIN_LOG2 (WIN_LOG2),
    .CNT_W    (CNT_W)
  ) u_window (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .restart   (rate_chg),
    .edge_i    (osc_rise),
    .win_end   (win_end),
    .cnt_final (cnt_final)
  );

  flm_lock_fsm #(
    .WIN_LOG2 (WIN_LOG2),
    .CNT_W    (CNT_W),
    .LOCK_PCT (LOCK_PCT),
    .DROP_PCT (DROP_PCT)
  ) u_fsm (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .rate_chg  (rate_chg),
    .rate_code (rate_q),
    .win_end   (win_end),
    .cnt_final (cnt_final),
    .harm_dq   (harm_dq),
    .state     (state),
    .done      (meas_done)
  );

  assign lock_det  = (state == ST_PHASE_ACQ);
  assign pa_active = (state == ST_PHASE_ACQ);

  // R2
  done_pulse_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    meas_done |=> !meas_done);

  // R8
  no_done_after_change_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    rate_chg |=> !meas_done);

endmodule

// File: tb/freq_lock_monitor_tb.sv
`timescale 1ns/1ps
module freq_lock_monitor_tb;
  localparam int WIN_LOG2 = 12;
  localparam int WIN      = 1 << WIN_LOG2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc = 1'b0;
  logic [2:0] rate_sel = 3'd4;
  logic       harm_dq = 1'b0;
  logic       lock_det, pa_active, meas_done;

  int    err_t = 0;          // frequency error, tenths of a percent
  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    finished = 1'b0;

  // reference model state
  int    m_k = 0;
  bit    m_lock = 1'b0;
  bit    m_done = 1'b0;
  logic [2:0] m_prev = 3'd0;
  string m_tag = "R1";

  freq_lock_monitor #(.WIN_LOG2(WIN_LOG2)) u_dut (
    .ref_clk   (clk),
    .rst_n     (rst_n),
    .osc_div_in(osc),
    .rate_sel  (rate_sel),
    .harm_dq   (harm_dq),
    .lock_det  (lock_det),
    .pa_active (pa_active),
    .meas_done (meas_done)
  );

  always #2.5 clk = ~clk;

  function automatic real base_period(input logic [2:0] c);
    case (c)
      3'd0: return 80.0;
      3'd1: return 60.0;
      3'd2: return 40.0;
      3'd3: return 30.0;
      3'd5: return 10.0;
      default: return 20.0;
    endcase
  endfunction

  initial begin
    #1;
    forever begin
      real half;
      half = base_period(rate_sel) / (1.0 + err_t / 1000.0) / 2.0;
      #(half) osc = ~osc;
    end
  end

  // behavioural reference: counts windows, decides from the applied error
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_k = 0; m_lock = 0; m_done = 0; m_prev = 3'd0; m_tag = "R1";
    end else begin
      m_done = 0;
      if (rate_sel != m_prev) begin
        m_prev = rate_sel; m_k = 0; m_lock = 0; m_tag = "R8";
      end else begin
        m_k = m_k + 1;
        if (m_k == WIN) begin
          int a;
          m_k = 0;
          m_done = 1;
          a = (err_t < 0) ? -err_t : err_t;
          if (harm_dq) begin
            m_lock = 0; m_tag = "R9";
          end else if (m_prev >= 3'd6) begin
            m_lock = 0; m_tag = "R10";
          end else if (!m_lock) begin
            m_lock = (a <= 10); m_tag = m_lock ? "R4" : "R5";
          end else begin
            m_lock = (a <= 20); m_tag = m_lock ? "R5" : "R6";
          end
        end
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(lock_det, m_lock, m_tag, "lock_det vs model");
      chk(pa_active, m_lock, "R7", "pa_active vs model");
      chk(meas_done, m_done, "R2", "meas_done vs model");
    end
  end

  task automatic summary;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      summary();
    end
  end

  task automatic wait_windows(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!m_done) @(negedge clk);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(lock_det, 1'b0, "R1", "lock_det in reset");
    chk(pa_active, 1'b0, "R1", "pa_active in reset");
    chk(meas_done, 1'b0, "R1", "meas_done in reset");
    rst_n = 1'b1;

    wait_windows(1);
    chk(lock_det, 1'b1, "R4", "lock at exact rate code 4");
    err_t = 15; wait_windows(2);
    chk(lock_det, 1'b1, "R5", "lock held at 1.5 percent");
    err_t = 30; wait_windows(1);
    chk(lock_det, 1'b0, "R6", "drop at 3 percent");
    err_t = 15; wait_windows(2);
    chk(lock_det, 1'b0, "R5", "no acquire at 1.5 percent");
    err_t = -5; wait_windows(1);
    chk(lock_det, 1'b1, "R4", "lock at -0.5 percent");

    harm_dq = 1'b1; wait_windows(1);
    chk(lock_det, 1'b0, "R9", "disqualify drops lock");
    harm_dq = 1'b0; wait_windows(1);
    chk(lock_det, 1'b1, "R9", "relock after disqualify clears");

    rate_sel = 3'd2; err_t = 0;
    @(negedge clk);
    chk(lock_det, 1'b0, "R8", "rate change clears lock");
    wait_windows(1);
    chk(lock_det, 1'b1, "R3", "lock on code 2");
    err_t = 30; wait_windows(1);
    chk(lock_det, 1'b0, "R6", "drop on code 2");
    err_t = 0; wait_windows(1);
    chk(lock_det, 1'b1, "R4", "relock on code 2");

    rate_sel = 3'd0;
    @(negedge clk);
    chk(lock_det, 1'b0, "R8", "rate change to code 0");
    wait_windows(1);
    chk(lock_det, 1'b1, "R3", "lock on code 0");
    rate_sel = 3'd5; wait_windows(1);
    chk(lock_det, 1'b1, "R3", "lock on code 5");

    rate_sel = 3'd6; wait_windows(2);
    chk(lock_det, 1'b0, "R10", "code 6 never locks");
    rate_sel = 3'd7; wait_windows(1);
    chk(lock_det, 1'b0, "R10", "code 7 never locks");

    rate_sel = 3'd4; err_t = -30; wait_windows(1);
    chk(lock_det, 1'b0, "R4", "no lock at -3 percent");
    err_t = -6; wait_windows(1);
    chk(lock_det, 1'b1, "R4", "lock at -0.6 percent");
    chk(pa_active, 1'b1, "R7", "phase acquisition while locked");

    repeat (3) @(negedge clk);
    chk(lock_det, 1'b1, "R11", "lock stable between closes");
    summary();
  end
endmodule